// File: doc/BRIEF.md
# CAN Receive Frame Buffer

This block buffers whole received CAN frames for a host. A frame receiver pushes the header and data bytes of one frame, one byte per cycle, into a shared circular byte store. An end-of-frame strobe then commits the frame. For each committed frame, a small companion queue records how many bytes were kept and whether any byte was lost because the byte store had no room.

The host reads the oldest committed frame through a fixed address window. In extended layout the window covers addresses 16 to 28, which is 13 bytes. In standard layout it covers addresses 20 to 29, which is 10 bytes. Address `base + k` returns byte `k` of the head frame, and any address outside the active window reads as zero. A release strobe discards the head frame as a whole. It advances the byte read pointer by the recorded length and the frame queue by one entry.

The block exports the count of committed bytes, the count of committed frames, and the overrun flag of the head frame. Bytes of a frame that is still being received are not counted until that frame is committed.

Top module: `can_rx_frame_fifo`

## Requirements
- R1: After reset, `byte_count` and `frame_count` are 0 and `head_overrun` is 0.
- R2: Bytes pushed before a commit leave `byte_count` and `frame_count` unchanged. On the clock edge of the commit strobe, `frame_count` rises by 1 and `byte_count` rises by the number of bytes kept from that frame. A byte pushed in the same cycle as the commit belongs to that frame.
- R3: Window mapping of the head frame:
  - When `ext_mode`=1, address 16+k returns byte k, for k = 0..12.
  - When `ext_mode`=0, address 20+k returns byte k, for k = 0..9.
  - Any other address returns 8'h00.
- R4: On a release strobe while frames are held, the head frame is discarded. `frame_count` falls by 1, `byte_count` falls by that frame's stored length, and the next frame appears in the window.
- R5: A frame whose byte total exactly fills the remaining room is stored completely with its overrun flag at 0. The byte store holds BYTE_DEPTH (64) bytes.
- R6: A frame that meets a full byte store is still committed. Bytes that do not fit are dropped, the stored length counts only the kept bytes (possibly 0), and the frame's overrun flag is set to 1.
- R7: `head_overrun` equals the overrun flag of the frame at the head of the queue, and it is 0 when no frame is held.
- R8: A release strobe while no frame is held has no effect on the counts or flags.
- R9: When INFO_DEPTH (32) frames are already held, a commit is discarded and the counts stay unchanged.
- R10: The byte pointers and frame pointers wrap around their storage. Frames that straddle the end of the byte store read back correctly.
- R11: A commit and a release on the same edge both take effect. The count of frames held stays the same, and `byte_count` changes by the new length minus the released length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | Selects the window layout: 1 = extended (16..28), 0 = standard (20..29) |
| wr_push | input | 1 | Receiver strobe: `wr_data` is the next byte of the current frame |
| wr_data | input | 8 | Frame byte from the receiver |
| wr_commit | input | 1 | Receiver end-of-frame strobe |
| rel_cmd | input | 1 | Host strobe that discards the head frame |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | 8 | Byte of the head frame at `rd_addr`, or 0 outside the window |
| byte_count | output | clog2(BYTE_DEPTH+1) | Committed bytes held |
| frame_count | output | clog2(INFO_DEPTH+1) | Committed frames held |
| head_overrun | output | 1 | Overrun flag of the head frame |

## Verification
The bench builds the block with its default sizes: a 64-byte store, a 32-entry frame queue and a 5-bit address. These sizes are small enough to fill the store exactly with five frames and to fill the frame queue with thirty-two one-byte frames. Several passes then drive both pointer sets across their wrap point. With these sizes the bench reaches the exact-fit case, the partial-fit and zero-fit overrun cases, the discarded thirty-third commit, and the combined commit-and-release edge, all within a few thousand cycles.

// File: rtl/can_rxf_pkg.sv
package can_rxf_pkg;

  // Read window layout: first address and span for each layout
  localparam int EXT_BASE = 16;
  localparam int EXT_SPAN = 13;
  localparam int STD_BASE = 20;
  localparam int STD_SPAN = 10;

  // True when addr falls in the window of the chosen layout
  function automatic logic win_hit(input logic ext, input int addr);
    if (ext) return (addr >= EXT_BASE) && (addr < EXT_BASE + EXT_SPAN);
    else     return (addr >= STD_BASE) && (addr < STD_BASE + STD_SPAN);
  endfunction

  // Byte index inside the head frame addressed by addr
  function automatic int win_off(input logic ext, input int addr);
    return ext ? addr - EXT_BASE : addr - STD_BASE;
  endfunction

  // A byte can still be kept when committed plus pending stays below depth
  function automatic logic byte_room(input int depth, input int held, input int pend);
    return (held + pend) < depth;
  endfunction

endpackage

// File: rtl/can_rxf_store.sv
module can_rxf_store #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/can_rxf_info.sv
module can_rxf_info #(
  parameter int DEPTH = 32,
  parameter int LEN_W = 7,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LEN_W-1:0] push_len,
  input  logic             push_ovr,
  input  logic             pop,
  output logic [LEN_W-1:0] head_len,
  output logic             head_ovr,
  output logic [CW-1:0]    count
);

  localparam int AW = $clog2(DEPTH);

  logic [LEN_W-1:0] len_q [DEPTH];
  logic             ovr_q [DEPTH];
  logic [AW-1:0]    wp, rp;

  // Named events for the assertions below
  logic do_push, do_pop;
  assign do_push = push && (count < CW'(DEPTH));
  assign do_pop  = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (do_push) begin
      len_q[wp] <= push_len;
      ovr_q[wp] <= push_ovr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  assign head_len = (count != '0) ? len_q[rp] : '0;
  assign head_ovr = (count != '0) && ovr_q[rp];

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count == '0 && !push) |=> (count == '0));

  assert_empty_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !head_ovr);

endmodule

// File: rtl/can_rx_frame_fifo.sv
module can_rx_frame_fifo #(
  parameter int BYTE_DEPTH = 64,
  parameter int INFO_DEPTH = 32,
  parameter int ADDR_W     = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              ext_mode,
  input  logic                              wr_push,
  input  logic [7:0]                        wr_data,
  input  logic                              wr_commit,
  input  logic                              rel_cmd,
  input  logic [ADDR_W-1:0]                 rd_addr,
  output logic [7:0]                        rd_data,
  output logic [$clog2(BYTE_DEPTH+1)-1:0]   byte_count,
  output logic [$clog2(INFO_DEPTH+1)-1:0]   frame_count,
  output logic                              head_overrun
);

  import can_rxf_pkg::*;

  localparam int BAW = $clog2(BYTE_DEPTH);
  localparam int BCW = $clog2(BYTE_DEPTH + 1);
  localparam int ICW = $clog2(INFO_DEPTH + 1);

  logic [BAW-1:0] rd_ptr, base_ptr;
  logic [BCW-1:0] held, pend, pend_nx, head_len;
  logic           pend_ovr, ovr_nx;
  logic [ICW-1:0] info_cnt;

  // Named internal events
  logic byte_fits, byte_drop, frame_taken, frame_lost, rel_take;

  always_comb begin
    byte_fits   = wr_push && byte_room(BYTE_DEPTH, int'(held), int'(pend));
    byte_drop   = wr_push && !byte_fits;
    pend_nx     = pend + BCW'(byte_fits);
    ovr_nx      = pend_ovr | byte_drop;
    frame_taken = wr_commit && (info_cnt < ICW'(INFO_DEPTH));
    frame_lost  = wr_commit && !frame_taken;
    rel_take    = rel_cmd && (info_cnt != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      base_ptr <= '0;
      held     <= '0;
      pend     <= '0;
      pend_ovr <= 1'b0;
    end else begin
      if (wr_commit) begin
        pend     <= '0;
        pend_ovr <= 1'b0;
        if (frame_taken) base_ptr <= base_ptr + BAW'(pend_nx);
      end else begin
        pend     <= pend_nx;
        pend_ovr <= ovr_nx;
      end
      if (rel_take) rd_ptr <= rd_ptr + BAW'(head_len);
      held <= held + (frame_taken ? pend_nx : '0) - (rel_take ? head_len : '0);
    end
  end

  // Byte store: write behind the committed region, read through the window
  logic           win_on;
  logic [BAW-1:0] raddr;
  logic [7:0]     store_q;

  assign win_on = win_hit(ext_mode, int'(rd_addr));
  assign raddr  = rd_ptr + BAW'(win_off(ext_mode, int'(rd_addr)));

  can_rxf_store #(.DEPTH(BYTE_DEPTH), .AW(BAW)) u_store (
    .clk   (clk),
    .we    (byte_fits),
    .waddr (base_ptr + BAW'(pend)),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (store_q)
  );

  can_rxf_info #(.DEPTH(INFO_DEPTH), .LEN_W(BCW)) u_info (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (frame_taken),
    .push_len (pend_nx),
    .push_ovr (ovr_nx),
    .pop      (rel_take),
    .head_len (head_len),
    .head_ovr (head_overrun),
    .count    (info_cnt)
  );

  assign rd_data     = win_on ? store_q : 8'h00;
  assign byte_count  = held;
  assign frame_count = info_cnt;

  assert_store_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (held + pend) <= BCW'(BYTE_DEPTH));

  assert_drop_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_drop && !wr_commit) |=> pend_ovr);

  assert_commit_adds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_taken && !rel_take) |=> (frame_count == $past(frame_count) + ICW'(1)));

  assert_release_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_take && !wr_commit) |=> (held == $past(held) - $past(head_len)));

  assert_full_queue_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_lost && !rel_cmd) |=> (frame_count == $past(frame_count) && held == $past(held)));

endmodule

// File: tb/can_rx_frame_fifo_test.sv
module can_rx_frame_fifo_test;

  logic       clk = 1'b0;
  logic       rst_n, ext_mode, wr_push, wr_commit, rel_cmd;
  logic [7:0] wr_data;
  logic [4:0] rd_addr;
  logic [7:0] rd_data;
  logic [6:0] byte_count;
  logic [5:0] frame_count;
  logic       head_overrun;

  always #5 clk = ~clk;

  can_rx_frame_fifo uut (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .wr_push(wr_push),
    .wr_data(wr_data), .wr_commit(wr_commit), .rel_cmd(rel_cmd),
    .rd_addr(rd_addr), .rd_data(rd_data), .byte_count(byte_count),
    .frame_count(frame_count), .head_overrun(head_overrun)
  );

  int checks = 0;
  int fails  = 0;

  // Reference model: committed bytes, per-frame lengths and flags, pending frame
  logic [7:0] mq [$];
  int         lq [$];
  bit         oq [$];
  logic [7:0] pb [$];
  bit         pend_o = 0;
  logic [7:0] nv = 8'h11;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    chk(req, byte_count, mq.size());
    chk(req, frame_count, lq.size());
    chk(req, head_overrun, (oq.size() != 0) ? oq[0] : 0);
  endtask

  task automatic check_window(string req, bit ext);
    int span, base, n;
    if (lq.size() == 0) return;
    span = ext ? 13 : 10;
    base = ext ? 16 : 20;
    n = (lq[0] < span) ? lq[0] : span;
    ext_mode = ext;
    for (int k = 0; k < n; k++) begin
      rd_addr = 5'(base + k);
      #1;
      chk(req, rd_data, mq[k]);
    end
  endtask

  task automatic push_byte();
    @(negedge clk);
    wr_push = 1'b1;
    wr_data = nv;
    if (mq.size() + pb.size() < 64) pb.push_back(nv);
    else pend_o = 1;
    nv = nv + 8'd37;
    @(negedge clk);
    wr_push = 1'b0;
  endtask

  task automatic model_commit();
    if (lq.size() < 32) begin
      foreach (pb[i]) mq.push_back(pb[i]);
      lq.push_back(pb.size());
      oq.push_back(pend_o);
    end
    pb.delete();
    pend_o = 0;
  endtask

  task automatic model_release();
    if (lq.size() > 0) begin
      repeat (lq[0]) void'(mq.pop_front());
      void'(lq.pop_front());
      void'(oq.pop_front());
    end
  endtask

  task automatic commit();
    @(negedge clk);
    wr_commit = 1'b1;
    model_commit();
    @(negedge clk);
    wr_commit = 1'b0;
  endtask

  task automatic release_head();
    @(negedge clk);
    rel_cmd = 1'b1;
    model_release();
    @(negedge clk);
    rel_cmd = 1'b0;
  endtask

  task automatic send_frame(int n);
    for (int i = 0; i < n; i++) push_byte();
    commit();
  endtask

  task automatic drain(string req);
    while (lq.size() > 0) begin
      check_window(req, 1'b1);
      release_head();
      check_state(req);
    end
  endtask

  // R1: state while in reset and after leaving it
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_state("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 after reset");
  endtask

  // R2, R3, R4: one full-size frame, both layouts, then release
  task automatic t_single();
    for (int i = 0; i < 13; i++) push_byte();
    check_state("R2 pending not counted");
    commit();
    check_state("R2 commit");
    check_window("R3 extended window", 1'b1);
    check_window("R3 standard window", 1'b0);
    ext_mode = 1'b1; rd_addr = 5'd15; #1; chk("R3 below extended", rd_data, 0);
    rd_addr = 5'd29; #1; chk("R3 above extended", rd_data, 0);
    ext_mode = 1'b0; rd_addr = 5'd19; #1; chk("R3 below standard", rd_data, 0);
    rd_addr = 5'd30; #1; chk("R3 above standard", rd_data, 0);
    release_head();
    check_state("R4 release");
  endtask

  // R8: release with nothing held
  task automatic t_empty_release();
    release_head();
    check_state("R8 empty release");
    rd_addr = 5'd0; #1; chk("R8 window idle", rd_data, 0);
  endtask

  // R5, R6, R7: exact fill, then a zero-fit overrun frame
  task automatic t_exact_fill();
    send_frame(13); send_frame(13); send_frame(13); send_frame(13); send_frame(12);
    check_state("R5 exact fill");
    chk("R5 full count", byte_count, 64);
    send_frame(5);
    check_state("R6 zero-fit overrun");
    drain("R7 drain after overrun");
  endtask

  // R6, R10: partial fit across the wrap point
  task automatic t_partial();
    send_frame(13); send_frame(13); send_frame(13); send_frame(13);
    send_frame(13);
    check_state("R6 partial fit");
    drain("R10 wrapped readback");
  endtask

  // R9: frame queue full
  task automatic t_info_full();
    for (int f = 0; f < 32; f++) send_frame(1);
    check_state("R9 queue full");
    send_frame(2);
    check_state("R9 extra commit dropped");
    drain("R9 drain");
  endtask

  // R11: commit and release on the same edge
  task automatic t_same_edge();
    send_frame(7);
    send_frame(4);
    for (int i = 0; i < 9; i++) push_byte();
    @(negedge clk);
    wr_commit = 1'b1;
    rel_cmd   = 1'b1;
    model_commit();
    model_release();
    @(negedge clk);
    wr_commit = 1'b0;
    rel_cmd   = 1'b0;
    check_state("R11 same edge");
    drain("R11 drain");
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    ext_mode = 1'b1; wr_push = 1'b0; wr_commit = 1'b0; rel_cmd = 1'b0;
    wr_data = 8'h00; rd_addr = 5'd0;
    t_reset();
    t_single();
    t_empty_release();
    t_exact_fill();
    t_partial();
    t_info_full();
    t_same_edge();
    t_partial();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule